// File: doc/BRIEF.md
# Boot Remap and Nonvolatile Region Decoder

This block sits between a 32-bit CPU's bus and the slow, nonvolatile memories of the board: system flash, two boot PROM sockets, battery-backed SRAM and a time-of-day clock chip. It also covers the small register window of the controller that contains it. For every bus cycle it picks at most one chip select. It checks the function code, transfer size and write permission, and ends the cycle with either a data acknowledge or a bus error.

Right after reset the block runs in a remap phase. Every address outside the controller's register window goes to the boot PROM, so the CPU's first fetches at 0x0 and 0x4 come from that device. Software ends the phase by asserting a control bit once. From then on the fixed memory map applies, and only a new reset brings the remap back.

SRAM cycles are stretched by a programmable wait count. An address that hits no region is ended with a bus error after a fixed timeout. A bus cycle is a plain strobe handshake with no streaming data path: the master holds address and qualifiers steady with the strobe high until it sees a one-clock acknowledge or bus error pulse, then drops the strobe.

Top module: `nvram_region_decoder`

## Requirements
- R1: After reset the block is in the remap phase. Every access outside the register window 0xFFD0_0000–0xFFD0_FFFF is acknowledged with a boot PROM select, with no size or function-code check. The select is `cs_boot_main` when `sw_boot_swap`=0 and `cs_boot_alt` when it is 1. Register-window accesses select `cs_ctl` in both phases.
- R2: A single clock with `ctl_boot_exit`=1 ends the remap phase permanently until the next reset.
- R3: After remap, 0xFFE0_0000–0xFFEF_FFFF is the boot PROM region. With `sw_boot_swap`=0, addr[19]=0 selects the main socket and addr[19]=1 selects the alternate socket. With `sw_boot_swap`=1 the whole region selects the alternate socket. Only byte transfers are acknowledged; other sizes get a bus error.
- R4: The flash region is 0xFF00_0000–0xFF3F_FFFF when `flash_8mb`=0 and 0xFF00_0000–0xFF7F_FFFF when it is 1.
- R5: Flash reads of any size are acknowledged. Flash writes get a bus error while `ctl_flash_wen`=0.
- R6: With `ctl_flash_wen`=1, a flash write is acknowledged only if it is long (size code 2'b11) and addr[1:0]=0. Otherwise it gets a bus error.
- R7: Function code 3'b111 to the flash, boot PROM or SRAM region gets a bus error.
- R8: The SRAM region is 0xFFC0_0000–0xFFCF_FFFF.
  - With `sw_sram_swap`=0, addr[19]=0 selects the main SRAM and addr[19]=1 matches no region.
  - With `sw_sram_swap`=1, addr[19]=1 selects the main SRAM and addr[19]=0 selects the alternate SRAM.
- R9: An SRAM acknowledge comes SRAM_UNIT×8, ×4, ×2 or ×1 clocks after the edge that samples the strobe, for `ctl_sram_wait` = 0, 1, 2 or 3. With the default SRAM_UNIT=12 at 50 MHz these are 1.92, 0.96, 0.48 and 0.24 µs.
- R10: 0xFF80_3000–0xFF80_30FF selects the clock chip. Byte transfers are acknowledged; other sizes get a bus error.
- R11: An access that matches no region gets a bus error TIMEOUT (64) clocks after the strobe is sampled, with no chip select.
- R12: Cycle timing and termination:
  - Out of reset all selects, `bus_ack` and `bus_berr` are low.
  - Every other termination comes 1 clock after the strobe is sampled.
  - A termination is a one-clock pulse of exactly one of `bus_ack` or `bus_berr`.
  - The chosen select is held from the clock after the strobe is sampled through the termination clock. No select is driven for a rejected cycle.
  - A new cycle starts only after the strobe has been low.
- Size codes: 2'b00 byte, 2'b01 word, 2'b10 three-byte, 2'b11 long. `bus_rd`=1 is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| bus_addr | input | 32 | byte address |
| bus_fc | input | 3 | function code |
| bus_size | input | 2 | transfer size code |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | cycle strobe, held until termination |
| sw_boot_swap | input | 1 | boot socket layout switch |
| sw_sram_swap | input | 1 | SRAM base swap switch, enables alternate SRAM |
| flash_8mb | input | 1 | fitted flash capacity, 1 = 8 MB |
| ctl_boot_exit | input | 1 | control bit ending the remap phase |
| ctl_flash_wen | input | 1 | control bit allowing flash writes |
| ctl_sram_wait | input | 2 | SRAM access time code |
| cs_flash | output | 1 | flash select |
| cs_boot_main | output | 1 | main boot socket select |
| cs_boot_alt | output | 1 | alternate boot socket select |
| cs_sram_main | output | 1 | main SRAM select |
| cs_sram_alt | output | 1 | alternate SRAM select |
| cs_clock | output | 1 | clock chip select |
| cs_ctl | output | 1 | controller register window select |
| bus_ack | output | 1 | data acknowledge pulse |
| bus_berr | output | 1 | bus error pulse |

## Verification
Each stimulus is a full bus cycle. The scoreboard checks three things for it: the termination kind, the select vector in the termination clock, and the latency from strobe to termination.

Remap-phase cycles use low addresses, flash addresses and the register window. These show that the remap overrides the decode while sparing the controller's registers. The same addresses after the exit pulse must decode normally, which separates the two phases.

Flash cycles sweep read/write, size, alignment and the enable bit, and separate each reason for rejection. Boot and SRAM cycles are repeated under both switch settings, with probes at addr[19] on each side. The four SRAM wait codes and the unmapped timeout are told apart by latency alone.

// File: rtl/nvdec_pkg.sv
package nvdec_pkg;

  localparam int NUM_SEL   = 7;
  localparam int SEL_FLASH = 0;
  localparam int SEL_BOOTM = 1;
  localparam int SEL_BOOTA = 2;
  localparam int SEL_SRAMM = 3;
  localparam int SEL_SRAMA = 4;
  localparam int SEL_CLOCK = 5;
  localparam int SEL_CTL   = 6;

  localparam logic [9:0]  FLASH4_TAG = 10'h3FC;   // 0xFF00_0000 / 4 MB
  localparam logic [8:0]  FLASH8_TAG = 9'h1FE;    // 0xFF00_0000 / 8 MB
  localparam logic [11:0] BOOT_TAG   = 12'hFFE;
  localparam logic [11:0] SRAM_TAG   = 12'hFFC;
  localparam logic [23:0] CLOCK_TAG  = 24'hFF8030;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'b00,
    SZ_WORD   = 2'b01,
    SZ_TRIPLE = 2'b10,
    SZ_LONG   = 2'b11
  } xfer_size_e;

  typedef enum logic [2:0] {
    RG_NONE, RG_REMAP, RG_FLASH, RG_BOOT, RG_SRAM, RG_CLOCK, RG_CTL
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_BUSY, ST_TERM
  } cyc_state_e;

endpackage

// File: rtl/nvdec_region_map.sv
module nvdec_region_map
  import nvdec_pkg::*;
#(
  parameter logic [15:0] CTL_TAG = 16'hFFD0
) (
  input  logic [31:0]        addr,
  input  logic               remap,
  input  logic               sw_boot_swap,
  input  logic               sw_sram_swap,
  input  logic               flash_8mb,
  output region_e            region,
  output logic [NUM_SEL-1:0] sel
);

  logic flash_hit;
  assign flash_hit = flash_8mb ? (addr[31:23] == FLASH8_TAG)
                               : (addr[31:22] == FLASH4_TAG);

  always_comb begin
    region = RG_NONE;
    sel    = '0;
    if (addr[31:16] == CTL_TAG) begin
      region       = RG_CTL;
      sel[SEL_CTL] = 1'b1;
    end else if (remap) begin
      region = RG_REMAP;
      if (sw_boot_swap) sel[SEL_BOOTA] = 1'b1;
      else              sel[SEL_BOOTM] = 1'b1;
    end else if (flash_hit) begin
      region         = RG_FLASH;
      sel[SEL_FLASH] = 1'b1;
    end else if (addr[31:20] == BOOT_TAG) begin
      region = RG_BOOT;
      if (sw_boot_swap || addr[19]) sel[SEL_BOOTA] = 1'b1;
      else                          sel[SEL_BOOTM] = 1'b1;
    end else if (addr[31:20] == SRAM_TAG) begin
      if (sw_sram_swap) begin
        region = RG_SRAM;
        if (addr[19]) sel[SEL_SRAMM] = 1'b1;
        else          sel[SEL_SRAMA] = 1'b1;
      end else if (!addr[19]) begin
        region         = RG_SRAM;
        sel[SEL_SRAMM] = 1'b1;
      end
    end else if (addr[31:8] == CLOCK_TAG) begin
      region         = RG_CLOCK;
      sel[SEL_CLOCK] = 1'b1;
    end
  end

endmodule

// File: rtl/nvdec_access_rules.sv
module nvdec_access_rules
  import nvdec_pkg::*;
#(
  parameter int SRAM_UNIT = 12,
  parameter int TIMEOUT   = 64,
  parameter int CNT_W     = 8
) (
  input  region_e          region,
  input  logic [2:0]       fc,
  input  logic [1:0]       size,
  input  logic             rd,
  input  logic [1:0]       addr_lo,
  input  logic             flash_wen,
  input  logic [1:0]       sram_wait,
  output logic             err,
  output logic [CNT_W-1:0] delay
);

  logic [CNT_W-1:0] wait_tab [4];
  for (genvar g = 0; g < 4; g++) begin : g_wait
    assign wait_tab[g] = CNT_W'(((SRAM_UNIT * 8) >> g) - 1);
  end

  logic fc_bad, byte_only, long_aligned;
  assign fc_bad       = (fc == 3'b111);
  assign byte_only    = (size == SZ_BYTE);
  assign long_aligned = (size == SZ_LONG) && (addr_lo == 2'b00);

  always_comb begin
    err   = 1'b0;
    delay = '0;
    case (region)
      RG_NONE: begin
        err   = 1'b1;
        delay = CNT_W'(TIMEOUT - 1);
      end
      RG_FLASH: err = fc_bad || (!rd && !(flash_wen && long_aligned));
      RG_BOOT:  err = fc_bad || !byte_only;
      RG_SRAM: begin
        err = fc_bad;
        if (!fc_bad) delay = wait_tab[sram_wait];
      end
      RG_CLOCK: err = !byte_only;
      default:  err = 1'b0;
    endcase
  end

endmodule

// File: rtl/nvdec_cycle_ctrl.sv
module nvdec_cycle_ctrl
  import nvdec_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               err,
  input  logic [CNT_W-1:0]   delay,
  input  logic [NUM_SEL-1:0] sel,
  output logic [NUM_SEL-1:0] cs,
  output logic               ack,
  output logic               berr
);

  cyc_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      err_q <= 1'b0;
      cs    <= '0;
      ack   <= 1'b0;
      berr  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (strobe) begin
          st    <= ST_BUSY;
          cnt   <= delay;
          err_q <= err;
          cs    <= err ? '0 : sel;
        end
        ST_BUSY: if (cnt == '0) begin
          st   <= ST_TERM;
          ack  <= !err_q;
          berr <= err_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_TERM: begin
          ack  <= 1'b0;
          berr <= 1'b0;
          cs   <= '0;
          if (!strobe) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nvram_region_decoder.sv
module nvram_region_decoder
  import nvdec_pkg::*;
#(
  parameter int          SRAM_UNIT = 12,
  parameter int          TIMEOUT   = 64,
  parameter logic [15:0] CTL_TAG   = 16'hFFD0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic [2:0]  bus_fc,
  input  logic [1:0]  bus_size,
  input  logic        bus_rd,
  input  logic        bus_strobe,
  input  logic        sw_boot_swap,
  input  logic        sw_sram_swap,
  input  logic        flash_8mb,
  input  logic        ctl_boot_exit,
  input  logic        ctl_flash_wen,
  input  logic [1:0]  ctl_sram_wait,
  output logic        cs_flash,
  output logic        cs_boot_main,
  output logic        cs_boot_alt,
  output logic        cs_sram_main,
  output logic        cs_sram_alt,
  output logic        cs_clock,
  output logic        cs_ctl,
  output logic        bus_ack,
  output logic        bus_berr
);

  localparam int WAIT_MAX = (TIMEOUT > SRAM_UNIT * 8) ? TIMEOUT : SRAM_UNIT * 8;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  logic               boot_q;
  region_e            region;
  logic [NUM_SEL-1:0] sel, cs;
  logic               err;
  logic [CNT_W-1:0]   delay;

  // remap phase: set by reset, cleared once by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             boot_q <= 1'b1;
    else if (ctl_boot_exit) boot_q <= 1'b0;
  end

  nvdec_region_map #(.CTL_TAG(CTL_TAG)) u_map (
    .addr         (bus_addr),
    .remap        (boot_q),
    .sw_boot_swap (sw_boot_swap),
    .sw_sram_swap (sw_sram_swap),
    .flash_8mb    (flash_8mb),
    .region       (region),
    .sel          (sel)
  );

  nvdec_access_rules #(.SRAM_UNIT(SRAM_UNIT), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_rules (
    .region    (region),
    .fc        (bus_fc),
    .size      (bus_size),
    .rd        (bus_rd),
    .addr_lo   (bus_addr[1:0]),
    .flash_wen (ctl_flash_wen),
    .sram_wait (ctl_sram_wait),
    .err       (err),
    .delay     (delay)
  );

  nvdec_cycle_ctrl #(.CNT_W(CNT_W)) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (bus_strobe),
    .err    (err),
    .delay  (delay),
    .sel    (sel),
    .cs     (cs),
    .ack    (bus_ack),
    .berr   (bus_berr)
  );

  assign cs_flash     = cs[SEL_FLASH];
  assign cs_boot_main = cs[SEL_BOOTM];
  assign cs_boot_alt  = cs[SEL_BOOTA];
  assign cs_sram_main = cs[SEL_SRAMM];
  assign cs_sram_alt  = cs[SEL_SRAMA];
  assign cs_clock     = cs[SEL_CLOCK];
  assign cs_ctl       = cs[SEL_CTL];

endmodule

// File: rtl/nvdec_checker.sv
module nvdec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd,
  input logic [1:0] size,
  input logic [1:0] addr_lo,
  input logic       boot_q,
  input logic [6:0] cs,
  input logic       ack,
  input logic       berr
);

  // R12: never both terminations at once
  a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && berr));

  // R12: at most one chip select
  a_r12_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));

  // R12: termination lasts one clock
  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ack || berr) |=> !(ack || berr));

  // R7 / R11: a rejected or unmapped cycle drives no select
  a_r7_err_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    berr |-> (cs == 7'b0));

  // R6: an acknowledged flash write is long and aligned
  a_r6_flash_write_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && cs[0] && !rd) |-> (size == 2'b11 && addr_lo == 2'b00));

  // R1: during remap only boot sockets or the register window answer
  a_r1_remap_target: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_q && ack) |-> (cs[1] || cs[2] || cs[6]));

  // R2: once left, the remap phase does not return
  a_r2_exit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_q |=> !boot_q);

endmodule

bind nvram_region_decoder nvdec_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd      (bus_rd),
  .size    (bus_size),
  .addr_lo (bus_addr[1:0]),
  .boot_q  (boot_q),
  .cs      ({cs_ctl, cs_clock, cs_sram_alt, cs_sram_main, cs_boot_alt, cs_boot_main, cs_flash}),
  .ack     (bus_ack),
  .berr    (bus_berr)
);

// File: tb/tb_nvram_region_decoder.sv
`timescale 1ns/1ps
module tb_nvram_region_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [2:0]  bus_fc = 3'b110;
  logic [1:0]  bus_size = 2'b11;
  logic        bus_rd = 1'b1;
  logic        bus_strobe = 1'b0;
  logic        sw_boot_swap = 1'b0, sw_sram_swap = 1'b0, flash_8mb = 1'b0;
  logic        ctl_boot_exit = 1'b0, ctl_flash_wen = 1'b0;
  logic [1:0]  ctl_sram_wait = 2'd3;
  logic        cs_flash, cs_boot_main, cs_boot_alt, cs_sram_main, cs_sram_alt, cs_clock, cs_ctl;
  logic        bus_ack, bus_berr;

  always #10 clk = ~clk;

  nvram_region_decoder dut (.*);

  typedef struct {
    logic       berr;
    logic [6:0] cs;
    int         lat;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, bad = 0;
  int   cnt = 0;
  logic done = 1'b0;
  logic [6:0] cs_now;
  assign cs_now = {cs_ctl, cs_clock, cs_sram_alt, cs_sram_main, cs_boot_alt, cs_boot_main, cs_flash};

  localparam logic [6:0] F = 7'h01, BM = 7'h02, BA = 7'h04, SM = 7'h08,
                         SA = 7'h10, CK = 7'h20, CT = 7'h40, NO = 7'h00;

  // monitor: measures latency and compares with the scoreboard
  initial forever begin
    @(posedge clk); #2;
    if (!rst_n || !bus_strobe) begin
      cnt  = 0;
      done = 1'b0;
    end else if (!done) begin
      cnt++;
      if (bus_ack || bus_berr) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (bus_berr !== e.berr || bus_ack !== !e.berr || cs_now !== e.cs || (cnt - 1) != e.lat) begin
          bad++;
          $display("FAIL %s: berr=%b cs=%h lat=%0d expected berr=%b cs=%h lat=%0d",
                   e.tag, bus_berr, cs_now, cnt - 1, e.berr, e.cs, e.lat);
        end
        done = 1'b1;
      end
    end
  end

  task automatic xfer(input logic [31:0] a, input logic [2:0] fc, input logic [1:0] sz,
                      input logic rd, input logic eb, input logic [6:0] ecs,
                      input int lat, input string tag);
    exp_t e;
    e.berr = eb; e.cs = ecs; e.lat = lat; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    bus_addr = a; bus_fc = fc; bus_size = sz; bus_rd = rd; bus_strobe = 1'b1;
    wait (done);
    @(negedge clk);
    bus_strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (cs_now !== NO || bus_ack !== 1'b0 || bus_berr !== 1'b0) begin
      bad++;
      $display("FAIL R12 reset: cs=%h ack=%b berr=%b expected 00 0 0", cs_now, bus_ack, bus_berr);
    end

    // R1 remap phase
    xfer(32'h0000_0000, 3'b110, 2'b11, 1, 0, BM, 1, "R1 fetch 0x0");
    xfer(32'h0000_0004, 3'b110, 2'b11, 1, 0, BM, 1, "R1 fetch 0x4");
    xfer(32'hFF00_0000, 3'b101, 2'b01, 1, 0, BM, 1, "R1 flash addr remapped");
    xfer(32'hFFD0_0010, 3'b101, 2'b11, 1, 0, CT, 1, "R1 register window");
    sw_boot_swap = 1'b1;
    xfer(32'h0000_0100, 3'b110, 2'b11, 1, 0, BA, 1, "R1 remap swapped socket");
    sw_boot_swap = 1'b0;

    // R2 end of remap
    @(negedge clk); ctl_boot_exit = 1'b1;
    @(negedge clk); ctl_boot_exit = 1'b0;
    xfer(32'h0000_0000, 3'b110, 2'b11, 1, 1, NO, 64, "R2 R11 low addr unmapped after exit");
    xfer(32'hFFD0_0000, 3'b101, 2'b00, 0, 0, CT, 1, "R2 register window after exit");

    // R4 / R5 flash map and reads
    xfer(32'hFF00_0002, 3'b101, 2'b01, 1, 0, F, 1, "R4 R5 flash word read");
    xfer(32'hFF3F_FFFF, 3'b101, 2'b00, 1, 0, F, 1, "R4 flash 4MB top");
    xfer(32'hFF40_0000, 3'b101, 2'b11, 1, 1, NO, 64, "R4 R11 beyond 4MB");
    flash_8mb = 1'b1;
    xfer(32'hFF40_0000, 3'b101, 2'b11, 1, 0, F, 1, "R4 inside 8MB");
    xfer(32'hFF80_0000, 3'b101, 2'b11, 1, 1, NO, 64, "R4 R11 beyond 8MB");
    flash_8mb = 1'b0;
    xfer(32'hFF00_0010, 3'b101, 2'b11, 0, 1, NO, 1, "R5 write disabled");

    // R6 enabled writes
    ctl_flash_wen = 1'b1;
    xfer(32'hFF00_0010, 3'b101, 2'b11, 0, 0, F, 1, "R6 aligned long write");
    xfer(32'hFF00_0012, 3'b101, 2'b11, 0, 1, NO, 1, "R6 misaligned long write");
    xfer(32'hFF00_0010, 3'b101, 2'b01, 0, 1, NO, 1, "R6 word write");
    ctl_flash_wen = 1'b0;

    // R7 function code 111
    xfer(32'hFF00_0000, 3'b111, 2'b11, 1, 1, NO, 1, "R7 flash fc7");
    xfer(32'hFFE0_0000, 3'b111, 2'b00, 1, 1, NO, 1, "R7 boot fc7");
    xfer(32'hFFC0_0000, 3'b111, 2'b00, 1, 1, NO, 1, "R7 sram fc7");

    // R3 boot PROM sockets
    xfer(32'hFFE0_0000, 3'b101, 2'b00, 1, 0, BM, 1, "R3 main socket");
    xfer(32'hFFE8_0000, 3'b101, 2'b00, 1, 0, BA, 1, "R3 alt socket");
    xfer(32'hFFE0_0000, 3'b101, 2'b01, 1, 1, NO, 1, "R3 word rejected");
    sw_boot_swap = 1'b1;
    xfer(32'hFFE0_0000, 3'b101, 2'b00, 1, 0, BA, 1, "R3 swapped low");
    xfer(32'hFFEF_FFFF, 3'b101, 2'b00, 1, 0, BA, 1, "R3 swapped high");
    sw_boot_swap = 1'b0;

    // R8 / R9 SRAM
    xfer(32'hFFC0_0000, 3'b101, 2'b00, 1, 0, SM, 12, "R8 R9 main sram code3");
    xfer(32'hFFC8_0000, 3'b101, 2'b00, 1, 1, NO, 64, "R8 R11 alt sram disabled");
    sw_sram_swap = 1'b1;
    xfer(32'hFFC8_0000, 3'b101, 2'b00, 0, 0, SM, 12, "R8 swapped main");
    xfer(32'hFFC0_0000, 3'b101, 2'b00, 1, 0, SA, 12, "R8 swapped alt");
    sw_sram_swap = 1'b0;
    ctl_sram_wait = 2'd0;
    xfer(32'hFFC0_0001, 3'b101, 2'b00, 1, 0, SM, 96, "R9 code0");
    ctl_sram_wait = 2'd1;
    xfer(32'hFFC0_0001, 3'b101, 2'b00, 1, 0, SM, 48, "R9 code1");
    ctl_sram_wait = 2'd2;
    xfer(32'hFFC0_0001, 3'b101, 2'b00, 1, 0, SM, 24, "R9 code2");
    ctl_sram_wait = 2'd3;

    // R10 clock chip
    xfer(32'hFF80_3005, 3'b101, 2'b00, 1, 0, CK, 1, "R10 clock byte");
    xfer(32'hFF80_3004, 3'b101, 2'b01, 0, 1, NO, 1, "R10 clock word rejected");

    // R11 plain unmapped
    xfer(32'h1234_5678, 3'b101, 2'b11, 1, 1, NO, 64, "R11 unmapped");

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R12 scoreboard: left=%0d expected 0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule